// File: doc/BRIEF.md
# Hub Port Change Interrupt Generator

This block merges event indications from the downstream ports of a USB hub repeater into one interrupt request for the interrupt controller. Each port reports three kinds of event as single-cycle pulses: a connect/disconnect change, babble, and resume. Babble and resume are reported only when that port's matching enable bit is set. A connect/disconnect change is always reported unless the port is currently forced, meaning it is held by override rather than driven by the serial engine.

Every qualified event sets a sticky flag in a per-port change record. The flags stay set until software writes a one to them through a clear strobe. The single hub request is a one-cycle pulse, issued whenever at least one flag goes from clear to set. Firmware reads the record to find which ports and which kinds of event caused the request.

Top module: `hub_chg_irq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every change flag reads 0 and the hub request is low.
- R2: A connect/disconnect pulse on port p that is not forced sets flag bit p (record bits [N-1:0] hold connect changes, one per port). The flag is visible one clock edge after the pulse, whatever that port's enable bits are.
- R3: A connect/disconnect pulse on a port whose forced input is high leaves the record unchanged and raises no request.
- R4: A babble pulse on port p sets flag bit N+p one edge later only when that port's babble enable is high. With the enable low it has no effect, and the forced input does not affect babble.
- R5: A resume pulse on port p sets flag bit 2N+p one edge later only when that port's resume enable is high. With the enable low it has no effect, and the forced input does not affect resume.
- R6: A set flag stays set until a cycle with the clear strobe high and a one in that flag's bit of the clear word. Zero bits in the clear word, and clear words written without the strobe, leave flags untouched.
- R7: When an event and a clear hit the same flag in the same cycle, the event wins and the flag is set after that edge.
- R8: The hub request is high for exactly the cycles in which at least one flag reads set that read clear in the cycle before. It rises together with the new flag and lasts one cycle when no further flag rises.
- R9: An event that hits a flag that is already set raises no request.
- R10: Events arriving together on several ports or of several kinds set all their flags on the same edge and produce a single one-cycle request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| conn_chg_i | input | NUM_PORTS | Per-port connect/disconnect change pulse |
| babble_i | input | NUM_PORTS | Per-port babble detected pulse |
| resume_i | input | NUM_PORTS | Per-port resume detected pulse |
| babble_en_i | input | NUM_PORTS | Per-port babble reporting enable |
| resume_en_i | input | NUM_PORTS | Per-port resume reporting enable |
| forced_i | input | NUM_PORTS | Per-port forced indication; masks connect changes |
| clr_we_i | input | 1 | Clear strobe for the change record |
| clr_bits_i | input | 3*NUM_PORTS | Write-one-to-clear mask, same layout as the record |
| chg_flags_o | output | 3*NUM_PORTS | Sticky change record: connect, then babble, then resume groups |
| irq_o | output | 1 | One-cycle hub interrupt request |

## Verification
An event pulse driven before a rising edge shows up in the change record and in the hub request after that same edge, so both are due one edge after the stimulus. The request must be back low one edge after that. A clear strobe takes effect on the edge that samples it. Inputs change on the falling edge and every check samples on the next falling edge, after the edge that makes the result due, so each result is read exactly in its due cycle. The sweep walks every port, every event kind, and every setting of the enable and forced inputs. A bench model computes each expected record and request from the rules.

// File: rtl/hub_chg_pkg.sv
package hub_chg_pkg;

   // Kinds of event tracked per port; the value is the group index in the record.
   typedef enum logic [1:0] {
      EVK_CONN   = 2'd0,
      EVK_BABBLE = 2'd1,
      EVK_RESUME = 2'd2
   } evt_kind_e;

   localparam int HUB_EVT_KINDS = 3;

   // Position of a (kind, port) flag inside the change record.
   function automatic int flag_index(input evt_kind_e kind, input int port, input int nports);
      return int'(kind) * nports + port;
   endfunction

endpackage

// File: rtl/hub_evt_qual.sv
module hub_evt_qual
   import hub_chg_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter bit FORCE_MASKS = 1'b1,
   localparam int FLAG_W     = HUB_EVT_KINDS * NUM_PORTS
)(
   input  logic [NUM_PORTS-1:0] conn_chg_i,
   input  logic [NUM_PORTS-1:0] babble_i,
   input  logic [NUM_PORTS-1:0] resume_i,
   input  logic [NUM_PORTS-1:0] babble_en_i,
   input  logic [NUM_PORTS-1:0] resume_en_i,
   input  logic [NUM_PORTS-1:0] forced_i,
   output logic [FLAG_W-1:0]    set_req_o
);

   if (NUM_PORTS < 1 || NUM_PORTS > 16) begin : g_bad_ports
      $error("hub_evt_qual: NUM_PORTS must be 1..16");
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic conn_ok;

      // Variant choice: masking of connect changes by the forced flag.
      if (FORCE_MASKS) begin : g_mask
         assign conn_ok = conn_chg_i[p] & ~forced_i[p];
      end else begin : g_nomask
         assign conn_ok = conn_chg_i[p];
      end

      assign set_req_o[flag_index(EVK_CONN,   p, NUM_PORTS)] = conn_ok;
      assign set_req_o[flag_index(EVK_BABBLE, p, NUM_PORTS)] = babble_i[p] & babble_en_i[p];
      assign set_req_o[flag_index(EVK_RESUME, p, NUM_PORTS)] = resume_i[p] & resume_en_i[p];
   end

endmodule

// File: rtl/hub_flag_bank.sv
module hub_flag_bank #(
   parameter int FLAG_W   = 12,
   parameter bit SET_WINS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] set_req_i,
   input  logic              clr_we_i,
   input  logic [FLAG_W-1:0] clr_bits_i,
   output logic [FLAG_W-1:0] flags_q_o,
   output logic [FLAG_W-1:0] flags_d_o
);

   if (FLAG_W < 1) begin : g_bad_width
      $error("hub_flag_bank: FLAG_W must be positive");
   end

   logic [FLAG_W-1:0] clr_mask;
   logic [FLAG_W-1:0] flags_q;

   assign clr_mask = clr_bits_i & {FLAG_W{clr_we_i}};

   for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      // Variant choice: which of set and clear has priority on a collision.
      if (SET_WINS) begin : g_set_first
         assign flags_d_o[b] = (flags_q[b] & ~clr_mask[b]) | set_req_i[b];
      end else begin : g_clr_first
         assign flags_d_o[b] = (flags_q[b] | set_req_i[b]) & ~clr_mask[b];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) flags_q[b] <= 1'b0;
         else        flags_q[b] <= flags_d_o[b];
      end

      // R6: a set flag survives unless a clear aimed at it was written.
      p_hold_until_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[b] && !(clr_we_i && clr_bits_i[b])) |=> flags_q[b]);

      // R6: a flag only drops after a matching clear write.
      p_fall_needs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[b] && !flags_d_o[b]) |-> (clr_we_i && clr_bits_i[b]));

      // R7: an event colliding with a clear leaves the flag set.
      if (SET_WINS) begin : g_a_set_first
         p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (set_req_i[b] && clr_we_i && clr_bits_i[b]) |=> flags_q[b]);
      end
   end

   assign flags_q_o = flags_q;

endmodule

// File: rtl/hub_irq_pulse.sv
module hub_irq_pulse #(
   parameter int FLAG_W = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] flags_q_i,
   input  logic [FLAG_W-1:0] flags_d_i,
   output logic              irq_o
);

   logic [FLAG_W-1:0] rising;
   logic              irq_q;

   assign rising = flags_d_i & ~flags_q_i;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |rising;
   end

   assign irq_o = irq_q;

   // R8: a request always accompanies at least one newly set flag.
   p_irq_has_new_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ((flags_q_i & ~$past(flags_q_i)) != '0));

   // R8: every newly set flag is accompanied by a request.
   p_new_flag_has_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q_i & ~$past(flags_q_i)) != '0) |-> irq_q);

   // R9: with nothing newly set the request stays low.
   p_no_irq_on_stale_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rising == '0) |=> !irq_q);

endmodule

// File: rtl/hub_chg_irq.sv
module hub_chg_irq
   import hub_chg_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter bit SET_WINS  = 1'b1
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_PORTS-1:0]              conn_chg_i,
   input  logic [NUM_PORTS-1:0]              babble_i,
   input  logic [NUM_PORTS-1:0]              resume_i,
   input  logic [NUM_PORTS-1:0]              babble_en_i,
   input  logic [NUM_PORTS-1:0]              resume_en_i,
   input  logic [NUM_PORTS-1:0]              forced_i,
   input  logic                              clr_we_i,
   input  logic [HUB_EVT_KINDS*NUM_PORTS-1:0] clr_bits_i,
   output logic [HUB_EVT_KINDS*NUM_PORTS-1:0] chg_flags_o,
   output logic                              irq_o
);

   localparam int FLAG_W = HUB_EVT_KINDS * NUM_PORTS;

   logic [FLAG_W-1:0] set_req;
   logic [FLAG_W-1:0] flags_q;
   logic [FLAG_W-1:0] flags_d;

   hub_evt_qual #(
      .NUM_PORTS   (NUM_PORTS),
      .FORCE_MASKS (1'b1)
   ) u_qual (
      .conn_chg_i  (conn_chg_i),
      .babble_i    (babble_i),
      .resume_i    (resume_i),
      .babble_en_i (babble_en_i),
      .resume_en_i (resume_en_i),
      .forced_i    (forced_i),
      .set_req_o   (set_req)
   );

   hub_flag_bank #(
      .FLAG_W   (FLAG_W),
      .SET_WINS (SET_WINS)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_req_i  (set_req),
      .clr_we_i   (clr_we_i),
      .clr_bits_i (clr_bits_i),
      .flags_q_o  (flags_q),
      .flags_d_o  (flags_d)
   );

   hub_irq_pulse #(
      .FLAG_W (FLAG_W)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_q_i (flags_q),
      .flags_d_i (flags_d),
      .irq_o     (irq_o)
   );

   assign chg_flags_o = flags_q;

   // R1: reset clears the record and the request.
   p_reset_clears_r1: assert property (@(posedge clk)
      !rst_n |=> (chg_flags_o == '0 && !irq_o));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
      localparam int IC = NUM_PORTS * 0 + p;
      localparam int IB = NUM_PORTS * 1 + p;
      localparam int IR = NUM_PORTS * 2 + p;

      // R2, R3: a connect flag only rises after an unforced connect change.
      p_conn_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!chg_flags_o[IC] ##1 chg_flags_o[IC]) |-> $past(conn_chg_i[p] && !forced_i[p]));

      // R2: an unforced connect change sets its flag.
      p_conn_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (conn_chg_i[p] && !forced_i[p]) |=> chg_flags_o[IC]);

      // R4: a babble flag only rises after an enabled babble event.
      p_babble_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!chg_flags_o[IB] ##1 chg_flags_o[IB]) |-> $past(babble_i[p] && babble_en_i[p]));

      // R5: a resume flag only rises after an enabled resume event.
      p_resume_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!chg_flags_o[IR] ##1 chg_flags_o[IR]) |-> $past(resume_i[p] && resume_en_i[p]));
   end

endmodule

// File: tb/tb_hub_chg_irq.sv
module tb_hub_chg_irq;

   localparam int NP = 4;
   localparam int FW = 3 * NP;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NP-1:0] conn_chg, babble, resume, babble_en, resume_en, forced;
   logic          clr_we;
   logic [FW-1:0] clr_bits;
   logic [FW-1:0] flags;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   hub_chg_irq #(.NUM_PORTS(NP)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .conn_chg_i  (conn_chg),
      .babble_i    (babble),
      .resume_i    (resume),
      .babble_en_i (babble_en),
      .resume_en_i (resume_en),
      .forced_i    (forced),
      .clr_we_i    (clr_we),
      .clr_bits_i  (clr_bits),
      .chg_flags_o (flags),
      .irq_o       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      conn_chg = '0; babble = '0; resume = '0;
      clr_we = 1'b0; clr_bits = '0;
   endtask

   task automatic clear_all();
      clr_we = 1'b1; clr_bits = '1;
      tick();
      clr_we = 1'b0; clr_bits = '0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle();
      babble_en = '0; resume_en = '0; forced = '0;
      rst_n = 1'b0;
      repeat (3) tick();
      chk("R1 flags in reset", 32'(flags), 0);
      chk("R1 irq in reset", 32'(irq), 0);
      rst_n = 1'b1;
      tick();
      chk("R1 flags after reset", 32'(flags), 0);
      chk("R1 irq after reset", 32'(irq), 0);

      // Sweep: every port, kind, enable and forced setting.
      for (int p = 0; p < NP; p++) begin
         for (int k = 0; k < 3; k++) begin
            for (int en = 0; en < 2; en++) begin
               for (int fo = 0; fo < 2; fo++) begin
                  string tag;
                  bit    q;
                  babble_en = en ? '1 : '0;
                  resume_en = en ? '1 : '0;
                  forced    = fo ? '1 : '0;
                  if (k == 0) begin conn_chg[p] = 1'b1; q = !fo; tag = fo ? "R3" : "R2"; end
                  else if (k == 1) begin babble[p] = 1'b1; q = en; tag = "R4"; end
                  else begin resume[p] = 1'b1; q = en; tag = "R5"; end
                  tick();
                  idle();
                  chk(tag, 32'(flags), q ? (32'd1 << (k * NP + p)) : 32'd0);
                  chk("R8 irq with new flag", 32'(irq), 32'(q));
                  tick();
                  chk("R8 irq lasts one cycle", 32'(irq), 0);
                  clear_all();
                  chk("R6 clear by write one", 32'(flags), 0);
               end
            end
         end
      end
      babble_en = '0; resume_en = '0; forced = '0;

      // R9: repeat event on an already set flag.
      conn_chg[1] = 1'b1; tick(); idle();
      chk("R2 setup", 32'(flags), 32'h002);
      tick();
      conn_chg[1] = 1'b1; tick(); idle();
      chk("R9 no irq on set flag", 32'(irq), 0);
      chk("R9 flag kept", 32'(flags), 32'h002);

      // R6: writes that must not clear.
      clr_we = 1'b1; clr_bits = '0; tick(); idle();
      chk("R6 zero word no effect", 32'(flags), 32'h002);
      clr_we = 1'b0; clr_bits = '1; tick(); idle();
      chk("R6 no strobe no effect", 32'(flags), 32'h002);
      clr_we = 1'b1; clr_bits = 12'h020; tick(); idle();
      chk("R6 other bit clear no effect", 32'(flags), 32'h002);

      // R7: collision of event and clear.
      conn_chg[1] = 1'b1; clr_we = 1'b1; clr_bits = 12'h002; tick(); idle();
      chk("R7 set flag survives collision", 32'(flags), 32'h002);
      chk("R7 no irq on survivor", 32'(irq), 0);
      conn_chg[2] = 1'b1; clr_we = 1'b1; clr_bits = 12'h004; tick(); idle();
      chk("R7 clear flag set on collision", 32'(flags), 32'h006);
      chk("R7 irq on collision set", 32'(irq), 1);
      tick();
      clear_all();
      chk("R6 clear all", 32'(flags), 0);

      // R10: simultaneous events across ports and kinds.
      babble_en = 4'b1000; resume_en = 4'b0100;
      conn_chg[0] = 1'b1; babble[3] = 1'b1; resume[2] = 1'b1;
      tick(); idle();
      chk("R10 all flags together", 32'(flags), 32'h401 | 32'h080);
      chk("R10 single irq", 32'(irq), 1);
      tick();
      chk("R10 irq one cycle", 32'(irq), 0);

      // R1: reset mid-run clears the record.
      rst_n = 1'b0; tick();
      chk("R1 reset clears flags", 32'(flags), 0);
      chk("R1 reset clears irq", 32'(irq), 0);
      rst_n = 1'b1; tick();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule